// File: doc/BRIEF.md
# Deferred Program-Halt Detector

This block sits beside an instruction-stepping datapath and decides when the running program has finished. On every step it looks at the instruction word being executed and at the current value of the link register (register 31). It recognises two finishing idioms: a branch-if-equal of register zero against itself whose offset sends it back to itself, and a jump-register through register 31 while that register holds zero. Once either is seen, a sticky halt flag is set and the block withdraws its commit permission. The datapath uses that permission to gate all register and memory writes, so architectural state stays frozen from the halting step onward.

The outside world is not told about the halt on every step. A modulo-C step counter, where C is supplied on a port, produces a one-cycle report strobe after every C-th step. The halt status seen on the report output is only meaningful while that strobe is high. The datapath may keep stepping for up to C-1 extra steps after the halt, and none of them commits anything.

Top module: `halt_watch`

## Requirements
- R1: During and right after reset, `halt_o`, `rpt_valid_o` and `rpt_done_o` are 0, and `commit_o` equals `step_i`.
- R2: A step whose instruction word is exactly 0x1000FFFF, a branch-if-equal of register 0 with itself and offset -1, sets `halt_o` to 1 in the cycle after that step.
- R3: A step whose instruction word is exactly 0x03E00008, a jump-register through register 31, sets `halt_o` in the next cycle only if `link_i` is 0. With any nonzero `link_i` it has no effect.
- R4: A step with any other instruction word, including near misses such as 0x1000FFFE, 0x1001FFFF or 0x03E00009, does not set `halt_o`.
- R5: An instruction word presented while `step_i` is 0 neither sets `halt_o` nor advances the report counter.
- R6: Once set, `halt_o` stays 1 on every later cycle until reset, whatever the inputs are.
- R7: `commit_o` is 1 only on a step taken while `halt_o` is 0 whose own instruction is not a halting idiom. The halting step itself and every later step get 0.
- R8: `rpt_valid_o` is a one-cycle pulse in the cycle after every C-th step counted since reset, where C is `period_i`. Otherwise it is 0.
- R9: While `rpt_valid_o` is 1, `rpt_done_o` is 1 exactly when a halting idiom was stepped at or before the C-th step that caused the pulse. While `rpt_valid_o` is 0, `rpt_done_o` is 0.
- R10: A `period_i` of 0 or 1 makes every step produce a report pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One instruction is executed in this cycle |
| instr_i | input | 32 | Instruction word of the current step |
| link_i | input | 32 | Current contents of register 31 |
| period_i | input | CNT_W (8) | Report period C in steps |
| commit_o | output | 1 | Architectural writes of this step are allowed |
| halt_o | output | 1 | Sticky halt flag |
| rpt_valid_o | output | 1 | Report strobe, one cycle after each C-th step |
| rpt_done_o | output | 1 | Halt status, meaningful with the strobe |

## Verification
Two functions can fall in the same cycle: detecting the halting idiom and closing a report period. The bench makes them collide by placing the halting instruction exactly on the C-th step, so the report that follows must already read 1 even though the sticky flag only rises on that same edge. It also places the halt one step before and one step after a boundary. The scoreboard's step model decides whether each pulse carries 1 or 0, and it checks at the same time that the commit permission drops on that very step.

// File: rtl/halt_watch_pkg.sv
package halt_watch_pkg;

    localparam int unsigned WORD_W = 32;

    // branch-if-equal r0,r0 with offset -1 (branch to itself)
    localparam logic [WORD_W-1:0] SELF_BRANCH_WORD = 32'h1000_FFFF;
    // jump-register through r31
    localparam logic [WORD_W-1:0] LINK_JUMP_WORD   = 32'h03E0_0008;

    typedef struct packed {
        logic halt;
    } flag_state_t;

endpackage

// File: rtl/halt_match.sv
module halt_match
    import halt_watch_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic [DW-1:0] instr_i,
    input  logic [DW-1:0] link_i,
    output logic          hit_o
);

    logic self_branch;
    logic link_jump;
    logic link_zero;

    always_comb begin
        self_branch = (instr_i == DW'(SELF_BRANCH_WORD));
        link_jump   = (instr_i == DW'(LINK_JUMP_WORD));
        link_zero   = (link_i == '0);
        hit_o       = self_branch | (link_jump & link_zero);
    end

endmodule

// File: rtl/halt_latch.sv
module halt_latch
    import halt_watch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic hit_i,
    output logic halt_o,
    output logic halt_now_o,
    output logic commit_o
);

    flag_state_t st_d;
    flag_state_t st_q;
    logic        seen;

    always_comb begin
        st_d     = st_q;
        seen     = step_i & hit_i;
        if (seen) begin
            st_d.halt = 1'b1;
        end
        halt_now_o = st_q.halt | seen;
        commit_o   = step_i & ~st_q.halt & ~hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign halt_o = st_q.halt;

endmodule

// File: rtl/halt_period.sv
module halt_period #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             halt_now_i,
    output logic             rpt_valid_o,
    output logic             rpt_done_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             valid;
        logic             done;
    } per_state_t;

    per_state_t       st_d;
    per_state_t       st_q;
    logic [CNT_W-1:0] last;
    logic             wrap;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.done  = 1'b0;
        last       = (period_i <= ONE) ? '0 : (period_i - ONE);
        wrap       = (st_q.cnt >= last);
        if (step_i) begin
            if (wrap) begin
                st_d.cnt   = '0;
                st_d.valid = 1'b1;
                st_d.done  = halt_now_i;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rpt_valid_o = st_q.valid;
    assign rpt_done_o  = st_q.done;

endmodule

// File: rtl/halt_watch.sv
module halt_watch
    import halt_watch_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] link_i,
    input  logic [CNT_W-1:0]  period_i,
    output logic              commit_o,
    output logic              halt_o,
    output logic              rpt_valid_o,
    output logic              rpt_done_o
);

    logic hit;
    logic halt_now;

    halt_match #(.DW(WORD_W)) u_match (
        .instr_i (instr_i),
        .link_i  (link_i),
        .hit_o   (hit)
    );

    halt_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step_i),
        .hit_i      (hit),
        .halt_o     (halt_o),
        .halt_now_o (halt_now),
        .commit_o   (commit_o)
    );

    halt_period #(.CNT_W(CNT_W)) u_period (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_i),
        .period_i    (period_i),
        .halt_now_i  (halt_now),
        .rpt_valid_o (rpt_valid_o),
        .rpt_done_o  (rpt_done_o)
    );

endmodule

// File: rtl/halt_watch_chk.sv
module halt_watch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        step_i,
    input logic [31:0] instr_i,
    input logic        commit_o,
    input logic        halt_o,
    input logic        rpt_valid_o,
    input logic        rpt_done_o
);

    // R2
    self_branch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && instr_i == 32'h1000_FFFF) |=> halt_o);

    // R5
    idle_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !halt_o) |=> !halt_o);

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    // R7
    frozen_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !commit_o);

    // R7
    commit_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> step_i);

    // R8
    pulse_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid_o |-> $past(step_i));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_valid_o |-> !rpt_done_o);

    // R9
    done_implies_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_done_o |-> halt_o);

endmodule

bind halt_watch halt_watch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .instr_i     (instr_i),
    .commit_o    (commit_o),
    .halt_o      (halt_o),
    .rpt_valid_o (rpt_valid_o),
    .rpt_done_o  (rpt_done_o)
);

// File: tb/sim_halt_watch.sv
`timescale 1ns/1ps
module sim_halt_watch;

    localparam logic [31:0] SELF_BR = 32'h1000_FFFF;
    localparam logic [31:0] LJUMP   = 32'h03E0_0008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] link_i = '0;
    logic [7:0]  period_i = 8'd3;
    logic        commit_o, halt_o, rpt_valid_o, rpt_done_o;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic  h;
        logic  v;
        logic  d;
        string tag;
    } exp_t;

    exp_t q[$];

    // model state
    logic m_halt;
    int   m_cnt;

    always #2 clk = ~clk;

    halt_watch u0 (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .instr_i(instr_i),
        .link_i(link_i), .period_i(period_i), .commit_o(commit_o),
        .halt_o(halt_o), .rpt_valid_o(rpt_valid_o), .rpt_done_o(rpt_done_o)
    );

    task automatic check1(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] per);
        @(negedge clk);
        rst_n    = 1'b0;
        step_i   = 1'b0;
        period_i = per;
        m_halt   = 1'b0;
        m_cnt    = 0;
        q.delete();
        #1;
        // R1 reset state
        check1("R1", "halt", halt_o, 1'b0);
        check1("R1", "valid", rpt_valid_o, 1'b0);
        check1("R1", "done", rpt_done_o, 1'b0);
        check1("R1", "commit", commit_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check1("R1", "halt after release", halt_o, 1'b0);
    endtask

    // driver: one cycle with given inputs, pushes expected post-edge outputs
    task automatic drive(input logic st, input logic [31:0] ins,
                         input logic [31:0] lnk, input string tag);
        logic hit;
        logic v;
        logic d;
        int   last;
        exp_t e;
        @(negedge clk);
        step_i  = st;
        instr_i = ins;
        link_i  = lnk;
        hit = (ins == SELF_BR) || (ins == LJUMP && lnk == 0);
        #1;
        // R7 commit permission of this step
        check1(tag, "commit (R7)", commit_o, st & ~m_halt & ~hit);
        v = 1'b0;
        d = 1'b0;
        if (st) begin
            m_halt = m_halt | hit;
            last = (period_i <= 1) ? 0 : int'(period_i) - 1;
            if (m_cnt >= last) begin
                m_cnt = 0;
                v = 1'b1;
                d = m_halt;
            end else begin
                m_cnt++;
            end
        end
        e.h = m_halt;
        e.v = v;
        e.d = d;
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check1(e.tag, "halt", halt_o, e.h);
                check1(e.tag, "rpt_valid", rpt_valid_o, e.v);
                check1(e.tag, "rpt_done", rpt_done_o, e.d);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        m_halt = 1'b0;
        m_cnt  = 0;
        // C = 3: near misses, no halt, periodic reports
        do_reset(8'd3);
        drive(1, 32'h0000_0000, 32'd0, "R4");
        drive(1, 32'h1000_FFFE, 32'd0, "R4");
        drive(1, 32'h1001_FFFF, 32'd0, "R8");
        drive(1, 32'h03E0_0009, 32'd0, "R4");
        drive(1, LJUMP, 32'd5, "R3");
        drive(1, LJUMP, 32'h8000_0000, "R3");
        // R5: halting words without a step
        drive(0, SELF_BR, 32'd0, "R5");
        drive(0, LJUMP, 32'd0, "R5");
        drive(0, 32'h0, 32'd0, "R5");
        drive(1, 32'h2108_0001, 32'd0, "R8");
        drive(1, 32'h2108_0001, 32'd0, "R8");
        // halting idiom lands exactly on the C-th step (R2, R9)
        drive(1, SELF_BR, 32'd0, "R2");
        for (int i = 0; i < 7; i++) begin
            drive(1, 32'h2108_0001, 32'd7, "R6");
            drive(0, 32'h0, 32'd7, "R6");
        end

        // C = 1: every step reports, jump-register with zero link halts
        do_reset(8'd1);
        drive(1, 32'h0, 32'd0, "R10");
        drive(1, 32'h0, 32'd0, "R10");
        drive(1, LJUMP, 32'd0, "R3");
        drive(1, 32'h0, 32'd0, "R10");
        drive(0, 32'h0, 32'd0, "R6");

        // C = 0 treated like 1
        do_reset(8'd0);
        drive(1, 32'h0, 32'd0, "R10");
        drive(1, 32'h0, 32'd0, "R10");
        drive(0, 32'h0, 32'd0, "R10");

        // C = 4: halt one step before a boundary, then one after
        do_reset(8'd4);
        drive(1, 32'h0, 32'd0, "R8");
        drive(1, 32'h0, 32'd0, "R8");
        drive(1, SELF_BR, 32'd0, "R9");
        drive(1, 32'h0, 32'd0, "R9");
        for (int i = 0; i < 5; i++) drive(1, 32'h0, 32'd1, "R9");

        do_reset(8'd4);
        for (int i = 0; i < 4; i++) drive(1, 32'h0, 32'd3, "R8");
        drive(1, LJUMP, 32'd0, "R9");
        for (int i = 0; i < 4; i++) drive(1, 32'h0, 32'd0, "R9");
        drive(0, 32'h0, 32'd0, "R9");
        drive(0, 32'h0, 32'd0, "R9");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule